// File: doc/BRIEF.md
# Reset Pulse Sequencer

This block controls the reset of a microcontroller that shares one active-low, open-drain reset pin with the rest of the board. It works in both directions. It watches the pin through a synchronizer, and it can also pull the pin low itself. A falling edge from outside, or any internal request line such as a watchdog timeout, starts a pull-down pulse. The pulse lasts a fixed number of state-time strobes. While the pulse runs, and for as long as the pin is still sensed low, the core is held in reset.

When the core is let go, the block raises a one-cycle start strobe and presents the address of the first instruction fetch. Entering reset also forces the power-mode output back to normal operation. An external reset can therefore wake the part from idle or powerdown.

Clock generation, the watchdog and test-mode decoding live outside this block. The `state_en` input marks one state time per high cycle. The board-level pin level is `pin_sense`, and `pin_pull` enables the open-drain pull-down.

Top module: `pin_reset_sequencer`

## Requirements
- R1: Any bit of `int_req` that is high at a clock edge sets `pin_pull` and `core_rst` to 1 after that same edge.
- R2: Once started, `pin_pull` stays high for exactly PULSE_LEN (default 16) strobes. A strobe is a clock edge at which `state_en` is 1, counted from the first edge after the start. `pin_pull` drops at the edge of the last strobe.
- R3: `pin_sense` passes through a 2-stage synchronizer. A falling edge seen while no pulse is active starts a pulse. `pin_pull` rises at the third clock edge after the pin goes low, and the pulse runs its full length even if the pin is released early.
- R4: An internal request during an active pulse restarts the count. The total number of strobes becomes the strobes already spent plus PULSE_LEN.
- R5: `core_rst` is 1 whenever `pin_pull` is 1. When the pin is high after the pulse, `core_rst` falls at the third clock edge after `pin_pull` falls. `core_start` is 1 for exactly the one cycle in which `core_rst` has just fallen.
- R6: `fetch_addr` equals RESET_VECTOR (default 24'hFF2080) whenever `core_start` is 1.
- R7: `mode_out` uses 00 for normal, 01 for idle and 10 for powerdown. It is forced to 00 at the edge where reset is entered, and it stays 00 while `core_rst` is 1, so a pin reset wakes the part from idle or powerdown. While the core runs, `mode_out` takes `mode_req` one edge later.
- R8: While the synchronous `rst` is high, `pin_pull` = 1, `core_rst` = 1, `core_start` = 0 and `mode_out` = 00. After `rst` falls, a full PULSE_LEN-strobe power-on pulse follows.
- R9: Reset is level-sensitive. If the pin is held low from outside past the end of the pulse, `core_rst` stays 1, and it falls at the third clock edge after the pin is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| state_en | input | 1 | One state-time strobe per high cycle |
| pin_sense | input | 1 | Sensed level of the shared reset pin (low = reset) |
| int_req | input | REQ_W | Internal reset requests, any bit high starts a pulse |
| mode_req | input | 2 | Requested power mode (00 normal, 01 idle, 10 powerdown) |
| pin_pull | output | 1 | Pull-down enable for the open-drain pin |
| core_rst | output | 1 | Active-high reset to the core |
| core_start | output | 1 | One-cycle strobe when the core leaves reset |
| mode_out | output | 2 | Applied power mode |
| fetch_addr | output | VEC_W | Address of the first fetch after reset |

## Verification
The assertions check on every cycle that a request starts the pull-down on the next edge, and that the core is in reset whenever the pin is pulled. They also check that the mode reads normal during reset, that the start strobe carries the reset vector, and that a pulse ending naturally has used exactly the configured number of strobes. The three-edge synchronizer delay on an external edge, the restart arithmetic, wake-up from each low-power mode, and the core being held while the pin is kept low from outside all depend on multi-step stimulus. Only the bench's sweeps over strobe spacing, request line, restart point and mode can show them.

// File: rtl/rstq_pkg.sv
package rstq_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_PDOWN = 2'b10,
    MODE_RSVD  = 2'b11
  } pwr_mode_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/rstq_sync.sv
// Multi-stage level synchronizer for the asynchronous pin sense.
module rstq_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= INIT;
          else     chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= INIT;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstq_fall_det.sv
// Falling-edge detector on the synchronized pin level, masked while the
// block itself is pulling the pin (its own pull must not retrigger it).
module rstq_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic mask,
  output logic fall
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b1;
    else     lvl_d <= lvl;
  end

  assign fall = lvl_d & ~lvl & ~mask;
endmodule

// File: rtl/rstq_pulse_timer.sv
// Counts state-time strobes while the pull-down is active.
// A start (re)loads the full length and has priority over a strobe.
module rstq_pulse_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic active
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b1;
      remain <= CW'(LEN);
    end else if (start) begin
      active <= 1'b1;
      remain <= CW'(LEN);
    end else if (active && tick) begin
      remain <= remain - CW'(1);
      if (remain == CW'(1)) active <= 1'b0;
    end
  end
endmodule

// File: rtl/rstq_release.sv
// Core reset, start strobe, power-mode override and fetch vector.
module rstq_release #(
  parameter int unsigned     VEC_W  = 24,
  parameter logic [VEC_W-1:0] VECTOR = 24'hFF2080
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             pulling,
  input  logic             pin_hi,
  input  logic [1:0]       mode_req,
  output logic             core_rst,
  output logic             core_start,
  output logic [1:0]       mode_out,
  output logic [VEC_W-1:0] fetch_addr
);
  import rstq_pkg::*;

  logic hold_d;

  assign hold_d = trig | pulling | ~pin_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst   <= 1'b1;
      core_start <= 1'b0;
      mode_out   <= MODE_RUN;
      fetch_addr <= VECTOR;
    end else begin
      core_rst   <= hold_d;
      core_start <= core_rst & ~hold_d;
      mode_out   <= hold_d ? MODE_RUN : mode_req;
      if (hold_d) fetch_addr <= VECTOR;
    end
  end
endmodule

// File: rtl/pin_reset_sequencer.sv
module pin_reset_sequencer #(
  parameter int unsigned      PULSE_LEN = 16,
  parameter int unsigned      REQ_W     = 3,
  parameter int unsigned      VEC_W     = 24,
  parameter logic [VEC_W-1:0] VECTOR    = 24'hFF2080
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             state_en,
  input  logic             pin_sense,
  input  logic [REQ_W-1:0] int_req,
  input  logic [1:0]       mode_req,
  output logic             pin_pull,
  output logic             core_rst,
  output logic             core_start,
  output logic [1:0]       mode_out,
  output logic [VEC_W-1:0] fetch_addr
);
  import rstq_pkg::*;

  logic pin_s;
  logic ext_fall;
  logic any_req;
  logic trig;

  rstq_sync #(.STAGES(SYNC_DEPTH), .INIT(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_sense),
    .q   (pin_s)
  );

  rstq_fall_det u_fall (
    .clk  (clk),
    .rst  (rst),
    .lvl  (pin_s),
    .mask (pin_pull),
    .fall (ext_fall)
  );

  assign any_req = |int_req;
  assign trig    = ext_fall | any_req;

  rstq_pulse_timer #(.LEN(PULSE_LEN)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (trig),
    .tick   (state_en),
    .active (pin_pull)
  );

  rstq_release #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_rel (
    .clk        (clk),
    .rst        (rst),
    .trig       (trig),
    .pulling    (pin_pull),
    .pin_hi     (pin_s),
    .mode_req   (mode_req),
    .core_rst   (core_rst),
    .core_start (core_start),
    .mode_out   (mode_out),
    .fetch_addr (fetch_addr)
  );
endmodule

// File: rtl/pin_reset_sequencer_chk.sv
module pin_reset_sequencer_chk #(
  parameter int unsigned      PULSE_LEN = 16,
  parameter int unsigned      REQ_W     = 3,
  parameter int unsigned      VEC_W     = 24,
  parameter logic [VEC_W-1:0] VECTOR    = 24'hFF2080
) (
  input logic             clk,
  input logic             rst,
  input logic             state_en,
  input logic [REQ_W-1:0] int_req,
  input logic             pin_pull,
  input logic             core_rst,
  input logic             core_start,
  input logic [1:0]       mode_out,
  input logic [VEC_W-1:0] fetch_addr
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 2);

  logic [CW-1:0] seen;

  // strobes consumed by the pulse in progress
  always_ff @(posedge clk) begin
    if (rst || !pin_pull || (|int_req)) seen <= '0;
    else if (state_en)                  seen <= seen + CW'(1);
  end

  AST_REQ_PULLS: assert property (@(posedge clk) disable iff (rst)
    (|int_req) |=> (pin_pull && core_rst)); // R1
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    ($fell(pin_pull) && !$past(|int_req)) |-> (seen == CW'(PULSE_LEN))); // R2
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    seen <= CW'(PULSE_LEN)); // R4
  AST_HOLD_CORE: assert property (@(posedge clk) disable iff (rst)
    pin_pull |-> core_rst); // R5
  AST_START_EDGE: assert property (@(posedge clk) disable iff (rst)
    core_start |-> (!core_rst && $past(core_rst))); // R5
  AST_START_VECTOR: assert property (@(posedge clk) disable iff (rst)
    core_start |-> (fetch_addr == VECTOR)); // R6
  AST_MODE_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> (mode_out == 2'b00)); // R7
endmodule

bind pin_reset_sequencer pin_reset_sequencer_chk #(
  .PULSE_LEN(PULSE_LEN), .REQ_W(REQ_W), .VEC_W(VEC_W), .VECTOR(VECTOR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .state_en   (state_en),
  .int_req    (int_req),
  .pin_pull   (pin_pull),
  .core_rst   (core_rst),
  .core_start (core_start),
  .mode_out   (mode_out),
  .fetch_addr (fetch_addr)
);

// File: tb/sim_pin_reset_sequencer.sv
`timescale 1ns/1ps
module sim_pin_reset_sequencer;
  localparam int LEN = 16;
  localparam int RW  = 3;
  localparam logic [23:0] VEC = 24'hFF2080;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic state_en = 1'b1;
  logic ext_low = 1'b0;
  logic [RW-1:0] int_req = '0;
  logic [1:0] mode_req = 2'b00;
  logic pin_sense, pin_pull, core_rst, core_start;
  logic [1:0] mode_out;
  logic [23:0] fetch_addr;

  int checks = 0;
  int errors = 0;
  int per = 1;
  int ph = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign pin_sense = ~(ext_low | pin_pull);

  pin_reset_sequencer u0 (
    .clk(clk), .rst(rst), .state_en(state_en), .pin_sense(pin_sense),
    .int_req(int_req), .mode_req(mode_req), .pin_pull(pin_pull),
    .core_rst(core_rst), .core_start(core_start), .mode_out(mode_out),
    .fetch_addr(fetch_addr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    ph = (ph + 1) % per;
    state_en = (ph == 0);
  endtask

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_pulse(output int n);
    n = 0;
    for (int g = 0; g < 2000 && pin_pull; g++) begin
      if (state_en) n++;
      tick();
    end
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (core_rst && n < 200) begin
      tick();
      n++;
    end
  endtask

  task automatic settle();
    for (int i = 0; i < 6; i++) tick();
  endtask

  initial begin
    int n;
    int r;
    int cnt;
    // R8: reset state
    tick(); tick();
    chk("R8 pull in reset", pin_pull, 1);
    chk("R8 core_rst in reset", core_rst, 1);
    chk("R8 start in reset", core_start, 0);
    chk("R8 mode in reset", mode_out, 0);
    rst = 1'b0;
    run_pulse(n);
    chk("R8 power-on pulse strobes", n, LEN);
    wait_release(r);
    chk("R5 release delay", r, 3);
    chk("R5 start strobe", core_start, 1);
    chk("R6 fetch vector", fetch_addr, VEC);
    tick();
    chk("R5 start one cycle", core_start, 0);
    settle();

    // R1/R2/R5 sweep over strobe spacing and request line
    for (int p = 1; p <= 4; p++) begin
      per = p;
      for (int b = 0; b < RW; b++) begin
        int_req = RW'(1) << b;
        tick();
        int_req = '0;
        chk("R1 request pulls", pin_pull, 1);
        chk("R1 request holds core", core_rst, 1);
        run_pulse(n);
        chk("R2 pulse strobes", n, LEN);
        wait_release(r);
        chk("R5 release delay", r, 3);
        chk("R6 fetch vector", fetch_addr, VEC);
        settle();
      end
    end

    // R4: restart at every point of the pulse
    for (int p = 1; p <= 2; p++) begin
      per = p;
      for (int k = 0; k < LEN; k++) begin
        int_req = 3'b001;
        tick();
        int_req = '0;
        cnt = 0;
        while (cnt < k) begin
          if (state_en) cnt++;
          tick();
        end
        chk("R4 still pulling before restart", pin_pull, 1);
        int_req = 3'b100;
        tick();
        int_req = '0;
        run_pulse(n);
        chk("R4 total strobes", cnt + n, k + LEN);
        wait_release(r);
        settle();
      end
    end

    // R3: external falling edge, short press
    for (int p = 1; p <= 3; p++) begin
      per = p;
      ext_low = 1'b1;
      tick(); tick();
      chk("R3 no pull before sync", pin_pull, 0);
      tick();
      chk("R3 pull on third edge", pin_pull, 1);
      ext_low = 1'b0;
      run_pulse(n);
      chk("R3 full pulse after short press", n, LEN);
      wait_release(r);
      chk("R5 release delay", r, 3);
      settle();
    end

    // R9: pin held low past the pulse
    per = 2;
    ext_low = 1'b1;
    tick(); tick(); tick();
    run_pulse(n);
    chk("R9 pulse strobes", n, LEN);
    for (int i = 0; i < 5; i++) tick();
    chk("R9 core held while pin low", core_rst, 1);
    ext_low = 1'b0;
    wait_release(r);
    chk("R9 release after pin high", r, 3);
    settle();

    // R7: follow and wake from idle / powerdown
    per = 1;
    for (int m = 1; m <= 2; m++) begin
      mode_req = 2'(m);
      tick();
      chk("R7 mode follows", mode_out, m);
      ext_low = 1'b1;
      tick(); tick(); tick();
      chk("R7 wake forces normal", mode_out, 0);
      ext_low = 1'b0;
      run_pulse(n);
      chk("R7 normal during pulse", mode_out, 0);
      wait_release(r);
      chk("R7 mode after release", mode_out, m);
      mode_req = 2'b00;
      settle();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule